// File: doc/BRIEF.md
# NOR Flash Command Controller

This block sits behind the parallel pins of a NOR-flash style device and turns bus write cycles into device actions. A write cycle (chip-enable and write-enable low, output-enable high) is committed when the first of chip-enable or write-enable returns high. Its low data byte is decoded as a command. The controller keeps track of what a read returns: array contents, the identifier words, or the status register. It runs the two-step program and erase sequences and handles erase suspend and resume.

Actual cell programming and erasing is left to an external engine. The controller starts it with a one-cycle request that carries the operation, the word address and the data to be written. It can ask the engine to pause or continue an erase. It waits for a done pulse, which may carry a failure flag. A program never turns a 0 back into a 1: the controller reads the current word and sends the AND of old and new contents. The bus can run 16 bits wide, or 8 bits wide with data bit 15 used as the byte-lane address.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A bus cycle counts as a write only while `ce_n`=0, `we_n`=0 and `oe_n`=1. Its address and data are the values present in the last clock cycle before `ce_n` or `we_n` goes high. A cycle with `oe_n` low has no effect.
- R2: Commands are decoded from `dq_in[7:0]` only. `dq_in[15:8]` and `word_mode` do not change how a command is decoded.
- R3: After reset the read path returns array data. Status reads 80h (ready, every other bit 0), and no engine request, suspend or resume is asserted.
- R4: FFh selects array reads. 90h selects identifier reads, which return `MFR_ID` when `addr[0]`=0 and `DEV_ID` when `addr[0]`=1. 70h selects status reads, which return {8'h00, status}.
- R5: 40h or 10h followed by one more write cycle asserts `eng_start` for exactly one cycle. With it come `eng_erase`=0, `eng_addr` set to the data-cycle address, and `eng_wdata` set to the stored word ANDed with the written data.
- R6: With `word_mode`=0, `dq_in[15]` selects the byte lane (1 = upper). A program puts `dq_in[7:0]` in that lane and FFh in the other lane. Array and identifier reads return {8'h00, selected byte}; identifier and status reads use the low byte.
- R7: 20h followed directly by D0h asserts `eng_start` with `eng_erase`=1, with `eng_addr` set to the address of the D0h cycle.
- R8: 20h followed by any code other than D0h sets status bits 5 and 4, starts nothing, and switches reads to status.
- R9: From `eng_start` until `eng_done`, status bit 7 is 0, reads return status, and writes are ignored, apart from R10. Read mode stays status afterwards.
- R10: B0h during an erase pulses `eng_suspend` and sets status bit 6 with bit 7 high. While suspended only FFh, 70h and D0h are honoured. D0h pulses `eng_resume` and returns to busy with bit 6 clear.
- R11: 50h clears status bits 5:3 without changing the read mode. A code outside the command set sets bit 3 and leaves the read mode unchanged. `eng_fail` with `eng_done` sets bit 4 after a program and bit 5 after an erase.
- R12: `dq_oe` is high exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus in; bit 15 is the byte-lane address in byte mode |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Read data drive enable |
| arr_addr | output | ADDR_W | Array read address |
| arr_rdata | input | 16 | Array read data |
| eng_start | output | 1 | One-cycle engine request |
| eng_erase | output | 1 | Request is an erase (else program) |
| eng_addr | output | ADDR_W | Target word address |
| eng_wdata | output | 16 | Merged program data |
| eng_suspend | output | 1 | Pause the running erase |
| eng_resume | output | 1 | Continue a paused erase |
| eng_done | input | 1 | Engine finished |
| eng_fail | input | 1 | Engine failure, valid with eng_done |

## Verification
The bench builds the controller with `ADDR_W`=6. A 64-word model array therefore covers the whole address space, including erase blocks at both ends. The identifier words 00A7h and 5B3Dh have low bytes that differ from their high bytes, so a wrong byte lane in byte mode shows up in the read data. The bench engine model takes a short time for programs and 30 cycles for the suspended erase. This keeps the engine busy long enough for suspend, the commands refused while suspended, and resume to happen in the middle of an operation.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

    localparam int DATA_W = 16;

    localparam logic [7:0] C_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] C_IDENT       = 8'h90;
    localparam logic [7:0] C_READ_STATUS = 8'h70;
    localparam logic [7:0] C_CLEAR       = 8'h50;
    localparam logic [7:0] C_ERASE_SETUP = 8'h20;
    localparam logic [7:0] C_CONFIRM     = 8'hD0;
    localparam logic [7:0] C_PROG_A      = 8'h40;
    localparam logic [7:0] C_PROG_B      = 8'h10;
    localparam logic [7:0] C_SUSPEND     = 8'hB0;

    // status bit positions
    localparam int SB_READY = 7;
    localparam int SB_SUSP  = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PROG_WAIT, ST_ERASE_WAIT, ST_ISSUE, ST_BUSY, ST_SUSP
    } ctl_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY, RM_IDENT, RM_STATUS
    } read_mode_e;

    typedef enum logic [3:0] {
        OP_READ_ARRAY, OP_IDENT, OP_READ_STATUS, OP_CLEAR, OP_ERASE_SETUP,
        OP_CONFIRM, OP_PROG_SETUP, OP_SUSPEND, OP_INVALID
    } cmd_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              word;
    } prog_data_t;

    function automatic cmd_op_e decode_cmd(input logic [7:0] code);
        case (code)
            C_READ_ARRAY:     return OP_READ_ARRAY;
            C_IDENT:          return OP_IDENT;
            C_READ_STATUS:    return OP_READ_STATUS;
            C_CLEAR:          return OP_CLEAR;
            C_ERASE_SETUP:    return OP_ERASE_SETUP;
            C_CONFIRM:        return OP_CONFIRM;
            C_PROG_A, C_PROG_B: return OP_PROG_SETUP;
            C_SUSPEND:        return OP_SUSPEND;
            default:          return OP_INVALID;
        endcase
    endfunction

    // new contents may only clear bits of the stored word
    function automatic logic [DATA_W-1:0] merge_prog(input logic [DATA_W-1:0] old,
                                                     input prog_data_t pd);
        logic [DATA_W-1:0] mask;
        if (pd.word)
            mask = pd.data;
        else if (pd.data[DATA_W-1])
            mask = {pd.data[7:0], 8'hFF};
        else
            mask = {8'hFF, pd.data[7:0]};
        return old & mask;
    endfunction

endpackage

// File: rtl/ncc_bus_capture.sv
module ncc_bus_capture #(
    parameter int ADDR_W = 19
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ce_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ncc_pkg::DATA_W-1:0] dq_in,
    input  logic                       word_mode,
    output logic                       cmd_valid,
    output logic [ADDR_W-1:0]          cap_addr,
    output logic [ncc_pkg::DATA_W-1:0] cap_data,
    output logic                       cap_word
);
    logic wr_act;
    logic act_q;

    assign wr_act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
            cap_word <= 1'b1;
        end else begin
            act_q <= wr_act;
            if (wr_act) begin
                cap_addr <= addr;
                cap_data <= dq_in;
                cap_word <= word_mode;
            end
        end
    end

    // commit on the first strobe to return high
    assign cmd_valid = act_q && (ce_n || we_n);

    a_r1_single_commit: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

endmodule

// File: rtl/ncc_seq.sv
module ncc_seq #(
    parameter int ADDR_W = 19
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [ADDR_W-1:0]          cap_addr,
    input  logic [ncc_pkg::DATA_W-1:0] cap_data,
    input  logic                       cap_word,
    input  logic [ncc_pkg::DATA_W-1:0] arr_rdata,
    input  logic                       eng_done,
    input  logic                       eng_fail,
    output logic                       eng_start,
    output logic                       eng_erase,
    output logic [ADDR_W-1:0]          eng_addr,
    output logic [ncc_pkg::DATA_W-1:0] eng_wdata,
    output logic                       eng_suspend,
    output logic                       eng_resume,
    output logic [7:0]                 status,
    output ncc_pkg::read_mode_e        read_mode
);
    import ncc_pkg::*;

    ctl_state_e  state;
    read_mode_e  rmode;
    cmd_op_e     op;
    logic [2:0]  sticky;     // [2]=erase err, [1]=program err, [0]=bad command
    logic        op_erase;
    logic [ADDR_W-1:0] tgt_addr;
    prog_data_t  tgt;
    logic        ready;

    assign op = decode_cmd(cap_data[7:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rmode       <= RM_ARRAY;
            sticky      <= '0;
            op_erase    <= 1'b0;
            tgt_addr    <= '0;
            tgt         <= '0;
            eng_suspend <= 1'b0;
            eng_resume  <= 1'b0;
        end else begin
            eng_suspend <= 1'b0;
            eng_resume  <= 1'b0;
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    case (op)
                        OP_READ_ARRAY:  rmode <= RM_ARRAY;
                        OP_IDENT:       rmode <= RM_IDENT;
                        OP_READ_STATUS: rmode <= RM_STATUS;
                        OP_CLEAR:       sticky <= '0;
                        OP_ERASE_SETUP: state <= ST_ERASE_WAIT;
                        OP_PROG_SETUP:  state <= ST_PROG_WAIT;
                        OP_INVALID:     sticky[0] <= 1'b1;
                        default: ;
                    endcase
                end
                ST_PROG_WAIT: if (cmd_valid) begin
                    tgt_addr <= cap_addr;
                    tgt      <= '{data: cap_data, word: cap_word};
                    op_erase <= 1'b0;
                    rmode    <= RM_STATUS;
                    state    <= ST_ISSUE;
                end
                ST_ERASE_WAIT: if (cmd_valid) begin
                    rmode <= RM_STATUS;
                    if (op == OP_CONFIRM) begin
                        tgt_addr <= cap_addr;
                        op_erase <= 1'b1;
                        state    <= ST_ISSUE;
                    end else begin
                        sticky[2:1] <= 2'b11;
                        state       <= ST_IDLE;
                    end
                end
                ST_ISSUE: state <= ST_BUSY;
                ST_BUSY: begin
                    if (eng_done) begin
                        state <= ST_IDLE;
                        if (eng_fail) begin
                            if (op_erase) sticky[2] <= 1'b1;
                            else          sticky[1] <= 1'b1;
                        end
                    end else if (cmd_valid && op == OP_SUSPEND && op_erase) begin
                        eng_suspend <= 1'b1;
                        rmode       <= RM_STATUS;
                        state       <= ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (eng_done) begin
                        state <= ST_IDLE;
                        if (eng_fail) sticky[2] <= 1'b1;
                    end else if (cmd_valid) begin
                        case (op)
                            OP_READ_ARRAY:  rmode <= RM_ARRAY;
                            OP_READ_STATUS: rmode <= RM_STATUS;
                            OP_CONFIRM: begin
                                eng_resume <= 1'b1;
                                rmode      <= RM_STATUS;
                                state      <= ST_BUSY;
                            end
                            default: ;
                        endcase
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ready     = !(state == ST_ISSUE || state == ST_BUSY);
    assign status    = {ready, state == ST_SUSP, sticky, 3'b000};
    assign eng_start = (state == ST_ISSUE);
    assign eng_erase = op_erase;
    assign eng_addr  = tgt_addr;
    assign eng_wdata = merge_prog(arr_rdata, tgt);

    always_comb begin
        if (state == ST_PROG_WAIT || state == ST_ERASE_WAIT || !ready)
            read_mode = RM_STATUS;
        else
            read_mode = rmode;
    end

    a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);
    a_r5_only_clears: assert property (@(posedge clk) disable iff (rst)
        (eng_start && !eng_erase) |-> ((eng_wdata & ~arr_rdata) == '0));
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !status[SB_READY]);
    a_r8_bad_sequence: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state == ST_ERASE_WAIT && op != OP_CONFIRM)
        |=> (status[5:4] == 2'b11 && !eng_start));
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state == ST_IDLE && op == OP_CLEAR) |=> (status[5:3] == 3'b000));
    a_r10_suspend_flag: assert property (@(posedge clk) disable iff (rst)
        eng_suspend |-> (status[SB_SUSP] && status[SB_READY]));
    a_r10_no_setup_in_susp: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP && cmd_valid)
        |=> (state != ST_PROG_WAIT && state != ST_ERASE_WAIT));

endmodule

// File: rtl/ncc_read_mux.sv
module ncc_read_mux #(
    parameter logic [15:0] MFR_ID = 16'h0089,
    parameter logic [15:0] DEV_ID = 16'h2299
) (
    input  ncc_pkg::read_mode_e        read_mode,
    input  logic                       word_mode,
    input  logic                       lane_hi,
    input  logic                       addr_lsb,
    input  logic [ncc_pkg::DATA_W-1:0] arr_rdata,
    input  logic [7:0]                 status,
    output logic [ncc_pkg::DATA_W-1:0] dq_out
);
    import ncc_pkg::*;

    logic [15:0] id_word;

    assign id_word = addr_lsb ? DEV_ID : MFR_ID;

    always_comb begin
        case (read_mode)
            RM_ARRAY: begin
                if (word_mode)    dq_out = arr_rdata;
                else if (lane_hi) dq_out = {8'h00, arr_rdata[15:8]};
                else              dq_out = {8'h00, arr_rdata[7:0]};
            end
            RM_IDENT:  dq_out = word_mode ? id_word : {8'h00, id_word[7:0]};
            default:   dq_out = {8'h00, status};
        endcase
    end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
    parameter int          ADDR_W = 19,
    parameter logic [15:0] MFR_ID = 16'h0089,
    parameter logic [15:0] DEV_ID = 16'h2299
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    input  logic              word_mode,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [15:0]       arr_rdata,
    output logic              eng_start,
    output logic              eng_erase,
    output logic [ADDR_W-1:0] eng_addr,
    output logic [15:0]       eng_wdata,
    output logic              eng_suspend,
    output logic              eng_resume,
    input  logic              eng_done,
    input  logic              eng_fail
);
    import ncc_pkg::*;

    logic              cmd_valid;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic              cap_word;
    logic [7:0]        status;
    read_mode_e        read_mode;

    ncc_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .word_mode(word_mode),
        .cmd_valid(cmd_valid), .cap_addr(cap_addr), .cap_data(cap_data),
        .cap_word(cap_word)
    );

    ncc_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cap_addr(cap_addr),
        .cap_data(cap_data), .cap_word(cap_word), .arr_rdata(arr_rdata),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_start(eng_start),
        .eng_erase(eng_erase), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_suspend(eng_suspend), .eng_resume(eng_resume),
        .status(status), .read_mode(read_mode)
    );

    ncc_read_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rd (
        .read_mode(read_mode), .word_mode(word_mode), .lane_hi(dq_in[15]),
        .addr_lsb(addr[0]), .arr_rdata(arr_rdata), .status(status),
        .dq_out(dq_out)
    );

    // the merge read uses the stored target while a program is issued
    assign arr_addr = (eng_start && !eng_erase) ? eng_addr : addr;
    assign dq_oe    = !ce_n && !oe_n && we_n;

endmodule

// File: tb/nor_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module nor_cmd_ctrl_bench;
    localparam int          AW  = 6;
    localparam logic [15:0] MFR = 16'h00A7;
    localparam logic [15:0] DEV = 16'h5B3D;

    typedef struct packed {
        logic [15:0] code;
        logic [5:0]  raddr;
        logic        wm;
        logic        lsb;
        logic [1:0]  kind;   // 0 literal, 1 array word, 2 array byte
        logic [15:0] val;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'h12FF, 6'd3, 1'b1, 1'b0, 2'd1, 16'h0000, 4'd2},  // R2
        '{16'h0090, 6'd0, 1'b1, 1'b0, 2'd0, MFR,      4'd4},  // R4
        '{16'hAB90, 6'd1, 1'b1, 1'b0, 2'd0, DEV,      4'd2},  // R2
        '{16'h0070, 6'd0, 1'b1, 1'b0, 2'd0, 16'h0080, 4'd3},  // R3
        '{16'h00FF, 6'd5, 1'b0, 1'b1, 2'd2, 16'h0000, 4'd6},  // R6
        '{16'h0000, 6'd5, 1'b1, 1'b0, 2'd1, 16'h0000, 4'd11}, // R11
        '{16'h0070, 6'd0, 1'b1, 1'b0, 2'd0, 16'h0088, 4'd11},
        '{16'hFF50, 6'd0, 1'b1, 1'b0, 2'd0, 16'h0080, 4'd11},
        '{16'h0090, 6'd1, 1'b0, 1'b0, 2'd0, {8'h00, DEV[7:0]}, 4'd6},
        '{16'h00FF, 6'd7, 1'b0, 1'b0, 2'd2, 16'h0000, 4'd6}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, arr_rdata, eng_wdata;
    logic dq_oe, eng_start, eng_erase, eng_suspend, eng_resume;
    logic [AW-1:0] arr_addr, eng_addr;
    logic eng_done, eng_fail;

    logic [15:0] mem [0:63];
    int   dur = 6;
    logic fail_next = 1'b0;
    int   cnt;
    logic susp, m_erase;
    logic [AW-1:0] m_addr;
    logic [15:0]   m_data;
    int total = 0, bad = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    nor_cmd_ctrl #(.ADDR_W(AW), .MFR_ID(MFR), .DEV_ID(DEV)) u_nor_cmd_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .word_mode(word_mode), .dq_out(dq_out),
        .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .eng_start(eng_start), .eng_erase(eng_erase), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_suspend(eng_suspend),
        .eng_resume(eng_resume), .eng_done(eng_done), .eng_fail(eng_fail)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'(i * 16'h0101) ^ 16'hA5C3;
    endfunction

    assign arr_rdata = mem[arr_addr];

    // engine and array model
    always @(posedge clk) begin
        eng_done <= 1'b0;
        eng_fail <= 1'b0;
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
            cnt <= 0; susp <= 1'b0; m_erase <= 1'b0; m_addr <= '0; m_data <= '0;
        end else begin
            if (eng_suspend) susp <= 1'b1;
            if (eng_resume)  susp <= 1'b0;
            if (eng_start) begin
                cnt <= dur; m_erase <= eng_erase; m_addr <= eng_addr; m_data <= eng_wdata;
            end else if (cnt == 1 && !susp) begin
                if (m_erase)
                    for (int j = 0; j < 16; j++) mem[{m_addr[5:4], 4'(j)}] <= 16'hFFFF;
                else
                    mem[m_addr] <= m_data;
                eng_done <= 1'b1;
                eng_fail <= fail_next;
                cnt <= 0;
            end else if (cnt > 1 && !susp) begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [AW-1:0] a, input logic wm);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; dq_in = d; addr = a; word_mode = wm;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; dq_in = '0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic wm, input logic lsb,
                      output logic [15:0] v);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; word_mode = wm;
        dq_in = {lsb, 15'h0};
        #1 v = dq_out;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; dq_in = '0;
    endtask

    initial begin
        logic [15:0] v, e;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset state
        chk("R3 no request", {13'b0, eng_start, eng_suspend, eng_resume}, 16'h0);
        rd(6'd5, 1'b1, 1'b0, v);
        chk("R3 array after reset", v, init_val(5));

        // table of single commands followed by one read
        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].code, 6'd0, VECS[k].wm);
            rd(VECS[k].raddr, VECS[k].wm, VECS[k].lsb, v);
            case (VECS[k].kind)
                2'd1:    e = init_val(int'(VECS[k].raddr));
                2'd2:    e = VECS[k].lsb ? {8'h00, init_val(int'(VECS[k].raddr)) >> 8}
                                         : {8'h00, init_val(int'(VECS[k].raddr)) & 16'h00FF};
                default: e = VECS[k].val;
            endcase
            chk($sformatf("R%0d vector %0d", VECS[k].req, k), v, e);
        end

        // R12: output enable
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; #1;
        chk("R12 oe during write", {15'b0, dq_oe}, 16'h0);
        we_n = 1'b1; #1;
        chk("R12 oe during read", {15'b0, dq_oe}, 16'h1);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);

        // R1: first rising strobe latches; later data change ignored
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; dq_in = 16'h0090; word_mode = 1'b1;
        @(negedge clk); we_n = 1'b1; dq_in = 16'h0070;
        @(negedge clk); ce_n = 1'b1; dq_in = '0;
        @(negedge clk);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R1 first edge capture", v, MFR);
        wr(16'h00FF, 6'd0, 1'b1);
        // R1: oe_n low makes the cycle no write
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; dq_in = 16'h0070;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; dq_in = '0;
        @(negedge clk);
        rd(6'd4, 1'b1, 1'b0, v);
        chk("R1 oe low ignored", v, init_val(4));

        // R5 / R9: word program
        dur = 8;
        wr(16'h0040, 6'd0, 1'b1);
        wr(16'hF0F0, 6'd9, 1'b1);
        chk("R5 start", {15'b0, eng_start}, 16'h1);
        chk("R5 kind", {15'b0, eng_erase}, 16'h0);
        chk("R5 addr", {10'b0, eng_addr}, 16'd9);
        chk("R5 merged data", eng_wdata, init_val(9) & 16'hF0F0);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R9 busy status", v, 16'h0000);
        wr(16'h00FF, 6'd0, 1'b1);           // ignored while busy
        repeat (20) @(negedge clk);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R9 mode kept status", v, 16'h0080);
        wr(16'h00FF, 6'd0, 1'b1);
        rd(6'd9, 1'b1, 1'b0, v);
        chk("R5 stored word", v, init_val(9) & 16'hF0F0);

        // R6: byte program, upper lane
        wr(16'h0010, 6'd0, 1'b0);
        wr(16'h800F, 6'd10, 1'b0);
        chk("R6 byte merge", eng_wdata, init_val(10) & 16'h0FFF);
        repeat (20) @(negedge clk);
        wr(16'h00FF, 6'd0, 1'b1);
        rd(6'd10, 1'b1, 1'b0, v);
        chk("R6 byte stored", v, init_val(10) & 16'h0FFF);

        // R7: erase
        wr(16'h0020, 6'd0, 1'b1);
        wr(16'h00D0, 6'h21, 1'b1);
        chk("R7 start erase", {14'b0, eng_start, eng_erase}, 16'h3);
        chk("R7 addr", {10'b0, eng_addr}, 16'h21);
        repeat (20) @(negedge clk);
        wr(16'h00FF, 6'd0, 1'b1);
        rd(6'h2A, 1'b1, 1'b0, v);
        chk("R7 block erased", v, 16'hFFFF);
        rd(6'h1F, 1'b1, 1'b0, v);
        chk("R7 neighbour kept", v, init_val(31));

        // R8: broken erase sequence
        wr(16'h0020, 6'd0, 1'b1);
        wr(16'h00FF, 6'd0, 1'b1);
        chk("R8 no start", {15'b0, eng_start}, 16'h0);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R8 status", v, 16'h00B0);
        wr(16'h0050, 6'd0, 1'b1);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R11 cleared", v, 16'h0080);

        // R10: suspend and resume
        dur = 30;
        wr(16'h0020, 6'd0, 1'b1);
        wr(16'h00D0, 6'h30, 1'b1);
        wr(16'h00B0, 6'd0, 1'b1);
        chk("R10 suspend pulse", {15'b0, eng_suspend}, 16'h1);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R10 suspended status", v, 16'h00C0);
        wr(16'h0040, 6'd0, 1'b1);           // refused while suspended
        wr(16'h0070, 6'd0, 1'b1);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R10 setup refused", v, 16'h00C0);
        wr(16'h00FF, 6'd0, 1'b1);
        rd(6'd2, 1'b1, 1'b0, v);
        chk("R10 array read in suspend", v, init_val(2));
        wr(16'h00D0, 6'd0, 1'b1);
        chk("R10 resume pulse", {15'b0, eng_resume}, 16'h1);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R10 busy again", v, 16'h0000);
        repeat (60) @(negedge clk);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R10 done status", v, 16'h0080);
        wr(16'h00FF, 6'd0, 1'b1);
        rd(6'h3F, 1'b1, 1'b0, v);
        chk("R10 erase completed", v, 16'hFFFF);

        // R11: engine failure on program
        dur = 6; fail_next = 1'b1;
        wr(16'h0040, 6'd0, 1'b1);
        wr(16'h1234, 6'd12, 1'b1);
        repeat (20) @(negedge clk);
        fail_next = 1'b0;
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R11 program error", v, 16'h0090);
        wr(16'h0050, 6'd0, 1'b1);
        rd(6'd0, 1'b1, 1'b0, v);
        chk("R11 clear after fail", v, 16'h0080);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule